// File: doc/BRIEF.md
# Half-Bridge Interlock Pulse Shaper

This block sits between a controller and the gate drivers of one half-bridge. It takes two command levels, one for the upper switch and one for the lower switch, and produces two gate-enable outputs. Each command first passes through its own glitch filter. A new level is taken only after it has stayed unchanged for a set number of clock cycles. Short noise pulses of either polarity are therefore dropped.

The filtered commands then pass through an interlock. The interlock never lets both enables be high at once. When one switch hands over to the other, it inserts a built-in dead time. That dead time is counted from the moment the outgoing enable falls. A gap that the controller already left is therefore absorbed rather than added on top. If the opposite side has been idle for long enough, a turn-on gets no extra delay. Overlapping commands are resolved quietly: the side that is already on keeps conducting, and the other side waits. No error indication is raised.

A force-off input drives both enables low on the next clock edge and overrides every other path. All timing is counted in cycles of the system clock. The filter window and the dead time are derived from nanosecond parameters and the clock period. The controller may drive the two commands from a single signal and its inverse.

Top module: `hb_interlock_shaper`

## Requirements
- R1: `hi_gate_o` and `lo_gate_o` are never both 1, for any input sequence.
- R2: A command pulse of either polarity that lasts fewer than FILT_CYC clock cycles leaves both outputs unchanged. With the defaults, FILT_CYC = 70 cycles of 10 ns, which is 700 ns, so every pulse shorter than 625 ns is dropped.
- R3: A command level held for FILT_CYC cycles or more is accepted, so every pulse longer than 750 ns passes. When no dead time is pending, the output changes on the (FILT_CYC+1)-th rising edge after the first edge that samples the new level.
- R4: On a complementary hand-over, the incoming output rises on the (DEAD_CYC+1)-th rising edge after the edge on which the outgoing output fell. With the defaults, DEAD_CYC = 20.
- R5: The built-in dead time and the controller's own gap are not summed. The incoming output rises at the later of two edges: the one set by its own filtered command (R3), and the one set by the dead time counted from the outgoing output's fall (R4).
- R6: A turn-on gets no dead-time delay when the opposite output has already been low for at least DEAD_CYC cycles. Its latency is exactly the R3 latency.
- R7: Overlapping commands raise no error, and the block has no error output. While one output is high, the other side's command is ignored until the first side's filtered command falls. If both filtered commands become high together while both outputs are low, both outputs stay low. When one of the two commands is then dropped, the other side turns on.
- R8: Driving the lower command as the inverse of the upper command produces alternating outputs, with the R4 dead time at every hand-over.
- R9: When `force_off_i` = 1 is sampled at a rising edge, both outputs are 0 after that edge, whatever the commands are. After release, the outputs follow the commands under R3 to R7 from the next edge.
- R10: During reset both outputs are 0. After reset both sides count as idle, so the first turn-on follows R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing counts its rising edges |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_cmd_i | input | 1 | Controller command for the upper switch (1 = on) |
| lo_cmd_i | input | 1 | Controller command for the lower switch (1 = on) |
| force_off_i | input | 1 | 1 forces both gate enables low on the next edge |
| hi_gate_o | output | 1 | Gate enable for the upper switch |
| lo_gate_o | output | 1 | Gate enable for the lower switch |

## Verification
Some behaviours are checked by assertions on every cycle:
- the enables are never high together;
- force-off clears both enables on the next edge;
- a filter only takes a level that its raw input held on the previous edge;
- an equal-time overlap from idle never turns either side on;
- a hand-over never closes a both-low gap shorter than the dead time.

The exact latencies need the bench's timed scenarios: filter acceptance on the FILT_CYC+1 edge, rejection of pulses one cycle short of the window, the max-not-sum rule with controller gaps longer and shorter than the dead time, and the immediate turn-on of a side whose opposite has been idle.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  // Side indices into the per-side vectors
  localparam int NSIDE = 2;
  localparam int HI    = 0;
  localparam int LO    = 1;

  // Counter width able to hold values 0..n
  function automatic int cnt_w(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/glitch_filter.sv
module glitch_filter #(
  parameter int STABLE_CYC = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic lvl_o
);
  import hbi_pkg::*;
  localparam int CW = cnt_w(STABLE_CYC - 1);

  logic [CW-1:0] run_q;
  logic          lvl_q;

  // A differing level must be seen on STABLE_CYC consecutive edges
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (raw_i == lvl_q) begin
      run_q <= '0;
    end else if (run_q == CW'(STABLE_CYC - 1)) begin
      lvl_q <= raw_i;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;

  // R2
  lvl_follows_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> ($past(raw_i) == lvl_q));
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int DEAD_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic ready_o
);
  import hbi_pkg::*;
  localparam int CW = cnt_w(DEAD_CYC);

  logic [CW-1:0] idle_q;

  // Cycles the watched enable has been low, saturating at DEAD_CYC.
  // Reset counts as long idle, so a first turn-on is not delayed.
  always_ff @(posedge clk) begin
    if (!rst_n)                        idle_q <= CW'(DEAD_CYC);
    else if (en_i)                     idle_q <= '0;
    else if (idle_q != CW'(DEAD_CYC))  idle_q <= idle_q + 1'b1;
  end

  assign ready_o = (idle_q == CW'(DEAD_CYC));
endmodule

// File: rtl/gate_arbiter.sv
module gate_arbiter
  import hbi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_off_i,
  input  logic [NSIDE-1:0] lvl_i,
  input  logic [NSIDE-1:0] idle_ok_i,
  output logic [NSIDE-1:0] gate_o
);
  logic [NSIDE-1:0] gate_q, gate_d;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam int O = NSIDE - 1 - s;
    // Hold while commanded. Start only when the other side is
    // uncommanded, off, and has been off for the dead time.
    assign gate_d[s] = !force_off_i && lvl_i[s] &&
                       (gate_q[s] || (!lvl_i[O] && !gate_q[O] && idle_ok_i[O]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= '0;
    else        gate_q <= gate_d;
  end

  assign gate_o = gate_q;

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_q[HI] && gate_q[LO]));

  // R9
  force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_off_i |=> (gate_q == '0));

  // R7
  tie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_i[HI] && lvl_i[LO] && gate_q == '0) |=> (gate_q == '0));
endmodule

// File: rtl/hb_interlock_shaper.sv
module hb_interlock_shaper
  import hbi_pkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int ACCEPT_NS = 700,
  parameter int DEAD_NS   = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_cmd_i,
  input  logic lo_cmd_i,
  input  logic force_off_i,
  output logic hi_gate_o,
  output logic lo_gate_o
);
  localparam int FILT_CYC = ACCEPT_NS / CLK_NS;
  localparam int DEAD_CYC = DEAD_NS / CLK_NS;
  localparam int GW       = cnt_w(DEAD_CYC + 1);

  logic [NSIDE-1:0] cmd_raw, cmd_lvl, idle_ok, gate;

  assign cmd_raw[HI] = hi_cmd_i;
  assign cmd_raw[LO] = lo_cmd_i;

  for (genvar s = 0; s < NSIDE; s++) begin : g_path
    glitch_filter #(.STABLE_CYC(FILT_CYC)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (cmd_raw[s]),
      .lvl_o (cmd_lvl[s])
    );
    idle_timer #(.DEAD_CYC(DEAD_CYC)) u_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (gate[s]),
      .ready_o (idle_ok[s])
    );
  end

  gate_arbiter u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .force_off_i (force_off_i),
    .lvl_i       (cmd_lvl),
    .idle_ok_i   (idle_ok),
    .gate_o      (gate)
  );

  assign hi_gate_o = gate[HI];
  assign lo_gate_o = gate[LO];

  // Independent observer of the both-low gap, used only by the checks below
  logic [GW-1:0]    gap_run;
  logic [NSIDE-1:0] last_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_run <= '0;
      last_on <= '0;
    end else if (|gate) begin
      gap_run <= '0;
      last_on <= gate;
    end else if (gap_run != GW'(DEAD_CYC + 1)) begin
      gap_run <= gap_run + 1'b1;
    end
  end

  // R4
  dead_gap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate[LO]) && $past(last_on[HI])) |-> ($past(gap_run) >= GW'(DEAD_CYC)));

  // R4
  dead_gap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate[HI]) && $past(last_on[LO])) |-> ($past(gap_run) >= GW'(DEAD_CYC)));
endmodule

// File: tb/test_hb_interlock_shaper.sv
module test_hb_interlock_shaper;
  logic clk = 1'b0;
  logic rst_n, hi, lo, blk;
  logic hi_g, lo_g;
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;  // 100 MHz
  always @(posedge clk) cyc <= cyc + 1;

  hb_interlock_shaper i_hb_interlock_shaper (
    .clk(clk), .rst_n(rst_n), .hi_cmd_i(hi), .lo_cmd_i(lo),
    .force_off_i(blk), .hi_gate_o(hi_g), .lo_gate_o(lo_g)
  );

  typedef struct {
    int   at;
    logic eh;
    logic el;
    int   req;
  } exp_t;
  exp_t q[$];

  // Driver side: push an expectation, keeping the queue sorted by cycle
  task automatic expect_at(input int at, input logic eh, input logic el, input int req);
    exp_t e;
    int   pos;
    e.at = at; e.eh = eh; e.el = el; e.req = req;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].at > at) begin pos = i; break; end
    end
    q.insert(pos, e);
  endtask

  task automatic go_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: compare outputs with expectations due this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.at != cyc || hi_g !== e.eh || lo_g !== e.el) begin
        failures++;
        $display("FAIL R%0d cycle %0d: actual hi=%b lo=%b expected hi=%b lo=%b",
                 e.req, e.at, hi_g, lo_g, e.eh, e.el);
      end
    end
  end

  // R1 continuous exclusion check
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      checks++;
      if (hi_g === 1'b1 && lo_g === 1'b1) begin
        failures++;
        $display("FAIL R1 cycle %0d: actual hi=1 lo=1 expected not both 1", cyc);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R0 watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c;
    rst_n = 1'b0; hi = 1'b0; lo = 1'b0; blk = 1'b0;
    repeat (5) @(negedge clk);
    // R10 outputs low in reset
    checks++;
    if (hi_g !== 1'b0 || lo_g !== 1'b0) begin
      failures++;
      $display("FAIL R10 reset: actual hi=%b lo=%b expected hi=0 lo=0", hi_g, lo_g);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 R6 R10 first lone turn-on, no dead-time delay
    c = cyc; hi = 1'b1;
    expect_at(c + 70, 0, 0, 3);
    expect_at(c + 71, 1, 0, 6);
    expect_at(c + 71, 1, 0, 10);
    go_to(c + 200);

    // R3 turn-off latency
    c = cyc; hi = 1'b0;
    expect_at(c + 70, 1, 0, 3);
    expect_at(c + 71, 0, 0, 3);
    go_to(c + 200);

    // R2 on-glitch one cycle short of the window
    c = cyc; hi = 1'b1; go_to(c + 69); hi = 1'b0;
    expect_at(c + 71, 0, 0, 2);
    expect_at(c + 150, 0, 0, 2);
    go_to(c + 200);
    c = cyc; hi = 1'b1; go_to(c + 200);

    // R2 off-glitch one cycle short of the window
    c = cyc; hi = 1'b0; go_to(c + 69); hi = 1'b1;
    expect_at(c + 71, 1, 0, 2);
    expect_at(c + 150, 1, 0, 2);
    go_to(c + 200);
    c = cyc; hi = 1'b0; go_to(c + 200);

    // R3 pulse of exactly the window passes with full width
    c = cyc; lo = 1'b1; go_to(c + 70); lo = 1'b0;
    expect_at(c + 70, 0, 0, 3);
    expect_at(c + 71, 0, 1, 3);
    expect_at(c + 140, 0, 1, 3);
    expect_at(c + 141, 0, 0, 3);
    go_to(c + 300);

    // R8 single signal and inverse; R4 dead time at each hand-over
    c = cyc; hi = 1'b1; lo = ~hi; go_to(c + 200);
    c = cyc; hi = 1'b0; lo = ~hi;
    expect_at(c + 70, 1, 0, 8);
    expect_at(c + 71, 0, 0, 4);
    expect_at(c + 91, 0, 0, 4);
    expect_at(c + 92, 0, 1, 4);
    go_to(c + 200);
    c = cyc; hi = 1'b1; lo = ~hi;
    expect_at(c + 71, 0, 0, 8);
    expect_at(c + 91, 0, 0, 4);
    expect_at(c + 92, 1, 0, 8);
    go_to(c + 200);

    // R5 controller gap of 40 cycles exceeds the dead time: no extra delay
    c = cyc; hi = 1'b0; go_to(c + 40); lo = 1'b1;
    expect_at(c + 71, 0, 0, 5);
    expect_at(c + 110, 0, 0, 5);
    expect_at(c + 111, 0, 1, 5);
    go_to(c + 250);

    // R5 controller gap of 10 cycles: dead time dominates
    c = cyc; lo = 1'b0; go_to(c + 10); hi = 1'b1;
    expect_at(c + 91, 0, 0, 5);
    expect_at(c + 92, 1, 0, 5);
    go_to(c + 250);

    // R7 overlap: the side already on holds, the other waits
    c = cyc; lo = 1'b1;
    expect_at(c + 100, 1, 0, 7);
    go_to(c + 150);
    c = cyc; hi = 1'b0;
    expect_at(c + 70, 1, 0, 7);
    expect_at(c + 71, 0, 0, 7);
    expect_at(c + 92, 0, 1, 7);
    go_to(c + 200);
    c = cyc; lo = 1'b0; go_to(c + 200);

    // R7 both commanded together from idle: neither starts
    c = cyc; hi = 1'b1; lo = 1'b1;
    expect_at(c + 100, 0, 0, 7);
    expect_at(c + 150, 0, 0, 7);
    go_to(c + 160);
    c = cyc; lo = 1'b0;
    expect_at(c + 70, 0, 0, 7);
    expect_at(c + 71, 1, 0, 7);
    go_to(c + 200);

    // R9 force-off overrides, then release
    c = cyc; blk = 1'b1;
    expect_at(c + 1, 0, 0, 9);
    hi = 1'b0; lo = 1'b1;
    expect_at(c + 150, 0, 0, 9);
    go_to(c + 160);
    c = cyc; blk = 1'b0;
    expect_at(c + 1, 0, 1, 9);
    go_to(c + 50);

    go_to(cyc + 5);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule